// File: doc/BRIEF.md
# Lookahead Redundant Switching-State Selector

This block serves a three-level clamped inverter modulator. For each voltage vector about to be applied it picks one of several 12-bit transistor patterns that all give the same output voltage. It chooses the pattern that toggles the fewest transistors. The choice is not made greedily. The block scores every legal pair of patterns for the next two vectors and then applies only the first pattern of the winning pair.

The block also keeps a signed running sum of capacitor charge time. Half-voltage patterns that draw from the upper capacitor add the dwell time of the applied vector, and patterns that draw from the lower capacitor subtract it. When the sum leaves a fixed band, patterns that would push it further out are no longer offered.

A caller presents the current pattern, the two upcoming vector indices and the dwell of the first one, and then pulses `start`. After a fixed scan the result appears together with a one-cycle `done`. The candidate catalogue is computed inside the block.

Top module: `sel_redundant_state`

## Requirements
- R1: A state word has 12 bits in three 4-bit legs: leg A at [11:8], B at [7:4], C at [3:0]. Inside a leg, bits 3..0 are switches T1..T4. Full level is 1100, zero level is 0011 and standard half level is 0110. Two alternative half patterns exist: T2 alone (0100) and T3 alone (0010).
- R2: Vector 0, and every index from 19 to 31, offers three neutral candidates in this order: all legs zero (0x333), all legs half (0x666), all legs full (0xCCC).
- R3: Vectors 1..6 are small vectors built from the large patterns of R4. In the upper variant, full stays full and zero becomes half. In the lower variant, full becomes half and zero stays zero. The candidates, in order, are: upper with standard half (tag C1), upper with T2-only half (C1), lower with standard half (C2), lower with T3-only half (C2).
- R4: Vectors 7..12 are large vectors with one neutral candidate each. Their levels (A,B,C, with 2=full, 1=half, 0=zero) are 200, 220, 020, 022, 002, 202. Vectors 13..18 are medium vectors with levels 210, 120, 021, 012, 102, 201. Each medium vector has three neutral candidates, in order: standard half leg, T2-only half leg, T3-only half leg.
- R5: The cost of a pair (i of the first vector, j of the second) is popcount(cur XOR cand_i) + popcount(cand_i XOR cand_j). The output is cand_i of the cheapest legal pair.
- R6: When two pairs cost the same, the pair with the lower first index wins. If the first indices are equal, the lower second index wins.
- R7: After reset the charge sum is 0. On each result, the first dwell is added when the chosen tag is C1 and subtracted when it is C2. A neutral result leaves the sum unchanged.
- R8: While the sum is above +NP_LIMIT (200), C1 candidates are illegal for both steps. While the sum is below −NP_LIMIT, C2 candidates are illegal for both steps. Neutral candidates are always legal.
- R9: `done` is high for exactly one cycle, 17 clock edges after the edge that accepts `start`. A `start`, or any input change, while a request is in flight has no effect on that request.
- R10: Under reset, `sel_state` is 0 and `done` is 0.
- R11: `sel_state` changes only in the cycle in which `done` is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| cur_state | input | 12 | Transistor pattern now applied |
| vec_first | input | 5 | Index of the next vector (committed) |
| vec_second | input | 5 | Index of the vector after it (lookahead only) |
| dwell_first | input | 8 | Dwell of the next vector, in time units |
| sel_state | output | 12 | Chosen pattern for the next vector |
| done | output | 1 | One-cycle result strobe |

## Verification
Two functions can act on the same result: the toggle-count minimisation and the charge-band restriction. This happens when a small vector's cheapest candidate carries the tag the sum forbids. The bench provokes it by applying the same upper small pattern repeatedly with a large dwell until the sum passes +200. It then expects the cheaper C1 pattern to be passed over for the cheapest C2 pattern, and it runs the mirrored walk below −200. Random requests are judged against a bench model that tracks the sum on its own, so every result that crosses a band edge also tests both functions together.

// File: rtl/sel_pkg.sv
package sel_pkg;

    localparam int LEG_W    = 4;
    localparam int NUM_LEGS = 3;
    localparam int STATE_W  = LEG_W * NUM_LEGS;
    localparam int NCAND    = 4;
    localparam int CIDX_W   = $clog2(NCAND);
    localparam int VEC_W    = 5;
    localparam int COST_W   = $clog2(2 * STATE_W + 1);

    typedef enum logic [1:0] {
        TAG_NONE = 2'd0,
        TAG_C1   = 2'd1,
        TAG_C2   = 2'd2
    } np_tag_e;

    typedef enum logic [1:0] {
        HALF_STD = 2'd0,
        HALF_UP  = 2'd1,
        HALF_LO  = 2'd2
    } half_e;

    // three 2-bit leg levels {A,B,C}: 2 full, 1 half, 0 zero
    typedef logic [2*NUM_LEGS-1:0] triple_t;

    typedef struct packed {
        logic                valid;
        np_tag_e             tag;
        logic [STATE_W-1:0]  bits;
    } cand_t;

    function automatic logic [LEG_W-1:0] leg_code(input logic [1:0] lvl, input half_e h);
        logic [LEG_W-1:0] r;
        case (lvl)
            2'd2:    r = 4'b1100;
            2'd0:    r = 4'b0011;
            default: begin
                case (h)
                    HALF_UP: r = 4'b0100;
                    HALF_LO: r = 4'b0010;
                    default: r = 4'b0110;
                endcase
            end
        endcase
        return r;
    endfunction

    function automatic logic [STATE_W-1:0] mk_state(input triple_t t, input half_e h);
        logic [STATE_W-1:0] s;
        for (int l = 0; l < NUM_LEGS; l++) begin
            s[l*LEG_W +: LEG_W] = leg_code(t[l*2 +: 2], h);
        end
        return s;
    endfunction

    function automatic triple_t large_tri(input int k);
        case (k)
            0:       return {2'd2, 2'd0, 2'd0};
            1:       return {2'd2, 2'd2, 2'd0};
            2:       return {2'd0, 2'd2, 2'd0};
            3:       return {2'd0, 2'd2, 2'd2};
            4:       return {2'd0, 2'd0, 2'd2};
            default: return {2'd2, 2'd0, 2'd2};
        endcase
    endfunction

    function automatic triple_t medium_tri(input int k);
        case (k)
            0:       return {2'd2, 2'd1, 2'd0};
            1:       return {2'd1, 2'd2, 2'd0};
            2:       return {2'd0, 2'd2, 2'd1};
            3:       return {2'd0, 2'd1, 2'd2};
            4:       return {2'd1, 2'd0, 2'd2};
            default: return {2'd2, 2'd0, 2'd1};
        endcase
    endfunction

    // upper: zero->half ; lower: full->half
    function automatic triple_t small_tri(input triple_t t, input logic upper);
        triple_t r;
        for (int l = 0; l < NUM_LEGS; l++) begin
            if (upper) r[l*2 +: 2] = (t[l*2 +: 2] == 2'd0) ? 2'd1 : 2'd2;
            else       r[l*2 +: 2] = (t[l*2 +: 2] == 2'd2) ? 2'd1 : 2'd0;
        end
        return r;
    endfunction

    function automatic triple_t flat_tri(input logic [1:0] lvl);
        return {lvl, lvl, lvl};
    endfunction

    function automatic cand_t cand_lookup(input logic [VEC_W-1:0] v, input int unsigned idx);
        cand_t c;
        int    vi;
        vi = int'(v);
        c  = '0;
        if (vi >= 1 && vi <= 6) begin
            c.valid = 1'b1;
            case (idx)
                0: begin c.bits = mk_state(small_tri(large_tri(vi-1), 1'b1), HALF_STD); c.tag = TAG_C1; end
                1: begin c.bits = mk_state(small_tri(large_tri(vi-1), 1'b1), HALF_UP);  c.tag = TAG_C1; end
                2: begin c.bits = mk_state(small_tri(large_tri(vi-1), 1'b0), HALF_STD); c.tag = TAG_C2; end
                default: begin c.bits = mk_state(small_tri(large_tri(vi-1), 1'b0), HALF_LO); c.tag = TAG_C2; end
            endcase
        end else if (vi >= 7 && vi <= 12) begin
            c.valid = (idx == 0);
            c.bits  = mk_state(large_tri(vi-7), HALF_STD);
        end else if (vi >= 13 && vi <= 18) begin
            c.valid = (idx < 3);
            c.bits  = mk_state(medium_tri(vi-13), half_e'(idx[1:0]));
        end else begin
            c.valid = (idx < 3);
            c.bits  = mk_state(flat_tri(idx[1:0]), HALF_STD);
        end
        return c;
    endfunction

    function automatic logic [COST_W-1:0] ones(input logic [STATE_W-1:0] x);
        logic [COST_W-1:0] n;
        n = '0;
        for (int b = 0; b < STATE_W; b++) n = n + COST_W'(x[b]);
        return n;
    endfunction

    function automatic logic tag_legal(input np_tag_e t, input logic c1_ok, input logic c2_ok);
        return (t == TAG_C1) ? c1_ok : (t == TAG_C2) ? c2_ok : 1'b1;
    endfunction

endpackage

// File: rtl/sel_cand_rom.sv
module sel_cand_rom
    import sel_pkg::*;
(
    input  logic [VEC_W-1:0]        vec,
    output cand_t [NCAND-1:0]       cands
);
    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        assign cands[g] = cand_lookup(vec, g);
    end
endmodule

// File: rtl/sel_pair_cost.sv
module sel_pair_cost
    import sel_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  cand_t              cand_i,
    input  cand_t              cand_j,
    input  logic               c1_ok,
    input  logic               c2_ok,
    output logic               legal,
    output logic [COST_W-1:0]  cost
);
    assign legal = cand_i.valid && cand_j.valid
                && tag_legal(cand_i.tag, c1_ok, c2_ok)
                && tag_legal(cand_j.tag, c1_ok, c2_ok);
    assign cost  = ones(cur ^ cand_i.bits) + ones(cand_i.bits ^ cand_j.bits);
endmodule

// File: rtl/sel_np_balance.sv
module sel_np_balance
    import sel_pkg::*;
#(
    parameter int ACC_W    = 12,
    parameter int DWELL_W  = 8,
    parameter int NP_LIMIT = 200
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  np_tag_e            tag,
    input  logic [DWELL_W-1:0] dwell,
    output logic               c1_ok,
    output logic               c2_ok
);
    localparam int MAX_SWING = NP_LIMIT + (2**DWELL_W - 1);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] dw_s;

    assign dw_s  = $signed({{(ACC_W-DWELL_W){1'b0}}, dwell});
    assign c1_ok = !(int'(acc_q) > NP_LIMIT);
    assign c2_ok = !(int'(acc_q) < -NP_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (commit) begin
            case (tag)
                TAG_C1:  acc_q <= acc_q + dw_s;
                TAG_C2:  acc_q <= acc_q - dw_s;
                default: acc_q <= acc_q;
            endcase
        end
    end

    // R7
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(acc_q) <= MAX_SWING) && (int'(acc_q) >= -MAX_SWING));
    // R8
    c1_block_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && int'(acc_q) > NP_LIMIT) |-> (tag != TAG_C1));
    // R8
    c2_block_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && int'(acc_q) < -NP_LIMIT) |-> (tag != TAG_C2));
endmodule

// File: rtl/sel_redundant_state.sv
module sel_redundant_state
    import sel_pkg::*;
#(
    parameter int DWELL_W  = 8,
    parameter int ACC_W    = 12,
    parameter int NP_LIMIT = 200
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [11:0]        cur_state,
    input  logic [4:0]         vec_first,
    input  logic [4:0]         vec_second,
    input  logic [DWELL_W-1:0] dwell_first,
    output logic [11:0]        sel_state,
    output logic               done
);
    localparam int PAIRS  = NCAND * NCAND;
    localparam int PAIR_W = $clog2(PAIRS);

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} phase_e;

    phase_e              ph_q;
    logic [STATE_W-1:0]  cur_q;
    logic [VEC_W-1:0]    va_q, vb_q;
    logic [DWELL_W-1:0]  dw_q;
    logic [PAIR_W-1:0]   pair_q;
    logic [CIDX_W-1:0]   best_q;
    logic [COST_W-1:0]   best_cost_q;
    logic                found_q;
    logic [STATE_W-1:0]  sel_q;
    logic                done_q;

    cand_t [NCAND-1:0]   cands_a, cands_b;
    logic [CIDX_W-1:0]   idx_i, idx_j;
    logic                pair_legal;
    logic [COST_W-1:0]   pair_cost;
    logic                c1_ok, c2_ok;
    logic                commit;

    assign idx_i  = pair_q[PAIR_W-1:CIDX_W];
    assign idx_j  = pair_q[CIDX_W-1:0];
    assign commit = (ph_q == ST_COMMIT);

    sel_cand_rom u_rom_a (.vec(va_q), .cands(cands_a));
    sel_cand_rom u_rom_b (.vec(vb_q), .cands(cands_b));

    sel_pair_cost u_cost (
        .cur    (cur_q),
        .cand_i (cands_a[idx_i]),
        .cand_j (cands_b[idx_j]),
        .c1_ok  (c1_ok),
        .c2_ok  (c2_ok),
        .legal  (pair_legal),
        .cost   (pair_cost)
    );

    sel_np_balance #(
        .ACC_W    (ACC_W),
        .DWELL_W  (DWELL_W),
        .NP_LIMIT (NP_LIMIT)
    ) u_bal (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .tag    (cands_a[best_q].tag),
        .dwell  (dw_q),
        .c1_ok  (c1_ok),
        .c2_ok  (c2_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q        <= ST_IDLE;
            cur_q       <= '0;
            va_q        <= '0;
            vb_q        <= '0;
            dw_q        <= '0;
            pair_q      <= '0;
            best_q      <= '0;
            best_cost_q <= '0;
            found_q     <= 1'b0;
            sel_q       <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q   <= cur_state;
                        va_q    <= vec_first;
                        vb_q    <= vec_second;
                        dw_q    <= dwell_first;
                        pair_q  <= '0;
                        found_q <= 1'b0;
                        ph_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pair_legal && (!found_q || pair_cost < best_cost_q)) begin
                        found_q     <= 1'b1;
                        best_q      <= idx_i;
                        best_cost_q <= pair_cost;
                    end
                    pair_q <= pair_q + 1'b1;
                    if (pair_q == PAIR_W'(PAIRS - 1)) ph_q <= ST_COMMIT;
                end
                default: begin
                    sel_q  <= cands_a[best_q].bits;
                    done_q <= 1'b1;
                    ph_q   <= ST_IDLE;
                end
            endcase
        end
    end

    assign sel_state = sel_q;
    assign done      = done_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(sel_q));
    // R8
    found_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (found_q && cands_a[best_q].valid));
    // R9
    latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == ST_SCAN) |=> ($stable(va_q) && $stable(vb_q) && $stable(cur_q)));
endmodule

// File: tb/sim_sel_redundant_state.sv
`timescale 1ns/1ps
module sim_sel_redundant_state;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] cur = '0;
    logic [4:0]  va = '0, vb = '0;
    logic [7:0]  dw = '0;
    logic [11:0] sel;
    logic        done;

    int total = 0;
    int bad   = 0;
    int m_acc = 0;

    always #2.5 clk = ~clk;

    sel_redundant_state u0 (
        .clk(clk), .rst(rst), .start(start), .cur_state(cur),
        .vec_first(va), .vec_second(vb), .dwell_first(dw),
        .sel_state(sel), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // R1 leg patterns; h: 0 standard, 1 T2 only, 2 T3 only
    function automatic bit [3:0] b_leg(input int l, input int h);
        if (l == 2) return 4'hC;
        if (l == 0) return 4'h3;
        if (h == 1) return 4'h4;
        if (h == 2) return 4'h2;
        return 4'h6;
    endfunction

    function automatic int b_large(input int k);
        case (k) 0: return 200; 1: return 220; 2: return 20;
                 3: return 22;  4: return 2;   default: return 202; endcase
    endfunction

    function automatic int b_medium(input int k);
        case (k) 0: return 210; 1: return 120; 2: return 21;
                 3: return 12;  4: return 102; default: return 201; endcase
    endfunction

    // R2 R3 R4 catalogue, tag 0 neutral, 1 C1, 2 C2
    function automatic void b_cand(input int v, input int i, output bit ok,
                                   output int tg, output bit [11:0] s);
        int code, h, lv[3];
        bit up;
        ok = 0; tg = 0; s = '0; h = 0; code = 0;
        if (v >= 1 && v <= 6) begin
            ok = 1; up = (i < 2); tg = up ? 1 : 2;
            h = (i == 1) ? 1 : (i == 3) ? 2 : 0;
            code = b_large(v - 1);
        end else if (v >= 7 && v <= 12) begin
            ok = (i == 0); code = b_large(v - 7);
        end else if (v >= 13 && v <= 18) begin
            ok = (i < 3); h = i; code = b_medium(v - 13);
        end else begin
            ok = (i < 3); code = i * 111;
        end
        lv[0] = code / 100; lv[1] = (code / 10) % 10; lv[2] = code % 10;
        if (v >= 1 && v <= 6) begin
            for (int l = 0; l < 3; l++) begin
                if (up) lv[l] = (lv[l] == 0) ? 1 : 2;
                else    lv[l] = (lv[l] == 2) ? 1 : 0;
            end
        end
        s = {b_leg(lv[0], h), b_leg(lv[1], h), b_leg(lv[2], h)};
    endfunction

    function automatic bit b_allow(input int tg);
        if (tg == 1) return !(m_acc > 200);
        if (tg == 2) return !(m_acc < -200);
        return 1'b1;
    endfunction

    // R5 R6 R8 reference pick
    function automatic void model_pick(input bit [11:0] c, input int a, input int b,
                                       output bit [11:0] s, output int tg);
        int best;
        best = 99; s = '0; tg = 0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                bit oi, oj;
                int ti, tj, cost;
                bit [11:0] si, sj;
                b_cand(a, i, oi, ti, si);
                b_cand(b, j, oj, tj, sj);
                if (oi && oj && b_allow(ti) && b_allow(tj)) begin
                    cost = $countones(c ^ si) + $countones(si ^ sj);
                    if (cost < best) begin best = cost; s = si; tg = ti; end
                end
            end
        end
    endfunction

    task automatic do_req(input bit [11:0] c, input int a, input int b, input int d,
                          input bit poke, input string req, output bit [11:0] res);
        bit [11:0] exp_s;
        int exp_tag, cnt;
        model_pick(c, a, b, exp_s, exp_tag);
        @(negedge clk);
        cur = c; va = a[4:0]; vb = b[4:0]; dw = d[7:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cnt = 0;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 3) begin
                start = 1'b1; cur = ~c; va = 5'd9; vb = 5'd14; dw = 8'd255;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(cnt == 17, "R9 latency", cnt, 17);
        chk(sel == exp_s, req, sel, exp_s);
        res = sel;
        if (exp_tag == 1) m_acc += d;
        if (exp_tag == 2) m_acc -= d;
        @(negedge clk);
        chk(!done, "R9 pulse width", done, 0);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL R9 watchdog got=hang exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [11:0] r, prev;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(sel == 12'h000, "R10 reset state", sel, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        @(negedge clk); rst = 1'b0;

        // R6 R2 all zero-vector candidates tie at 6
        do_req(12'h000, 0, 0, 10, 0, "R6 tie zero vector", r);
        chk(r == 12'h333, "R6 lowest index", r, 12'h333);
        // R2 index above 18 maps to zero vector
        do_req(12'h666, 25, 0, 10, 0, "R2 high index", r);
        chk(r == 12'h666, "R2 half flat", r, 12'h666);
        // R4 large and medium
        do_req(12'h000, 7, 7, 10, 0, "R4 large", r);
        chk(r == 12'hC33, "R4 large pattern", r, 12'hC33);
        do_req(12'hC23, 13, 13, 10, 0, "R4 medium alt", r);
        chk(r == 12'hC23, "R4 medium T3 pattern", r, 12'hC23);
        // R5 lookahead: greedy would take C44, pair cost ties 7 so index 0 wins
        do_req(12'h444, 1, 7, 0, 0, "R5 lookahead", r);
        chk(r == 12'hC66, "R5 pair cost", r, 12'hC66);

        // R7 R8 positive walk: +150, +150 -> 300, then C1 barred
        do_req(12'hC66, 1, 1, 150, 0, "R7 step1", r);
        chk(r == 12'hC66, "R7 upper chosen", r, 12'hC66);
        do_req(12'hC66, 1, 1, 150, 0, "R7 step2", r);
        chk(r == 12'hC66, "R7 upper again", r, 12'hC66);
        do_req(12'hC66, 1, 1, 150, 0, "R8 above band", r);
        chk(r == 12'h633, "R8 C1 barred", r, 12'h633);
        // R8 negative walk: 150 -> 0 -> -150 -> -300, then C2 barred
        do_req(12'h633, 1, 1, 150, 0, "R7 down1", r);
        do_req(12'h633, 1, 1, 150, 0, "R7 down2", r);
        do_req(12'h633, 1, 1, 150, 0, "R7 down3", r);
        chk(r == 12'h633, "R7 lower held", r, 12'h633);
        do_req(12'h633, 1, 1, 150, 0, "R8 below band", r);
        chk(r == 12'hC66, "R8 C2 barred", r, 12'hC66);

        // R9 start while busy is ignored
        do_req(12'h000, 13, 7, 20, 1, "R9 busy start ignored", r);

        // R11 hold with inputs moving and no start
        prev = sel;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cur = 12'($urandom); va = 5'($urandom); vb = 5'($urandom);
            chk(sel == prev, "R11 hold", sel, prev);
        end

        // R1 R3 R5 R8 random mix
        prev = sel;
        for (int n = 0; n < 300; n++) begin
            int a, b, d;
            bit [11:0] c;
            a = ($urandom % 10 < 5) ? 1 + ($urandom % 6) : int'($urandom % 32);
            b = ($urandom % 10 < 5) ? 1 + ($urandom % 6) : int'($urandom % 32);
            d = int'($urandom % 256);
            c = ($urandom % 2 == 0) ? prev : 12'($urandom);
            do_req(c, a, b, d, 0, "R5 random pick", r);
            prev = r;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule